// File: doc/BRIEF.md
# Burst De-Interleave Cache Router

This block sits between a memory controller and four line-cache RAMs that feed a processing engine working on a two-dimensional data matrix. In memory, each 8-word burst is interleaved: it holds words of two neighbouring range lines and four neighbouring azimuth lines. The block takes one such burst and spreads its words over the cache RAMs. It does this one RAM write per cycle, so that each RAM holds the words of one line in the line's own order. In range traversal only one pair of RAMs is written, picked by a pair-select input. In azimuth traversal all four RAMs are written.

A second, independent path runs the same mapping backwards. It issues reads to the four RAMs, collects the returned words, and presents one rebuilt 8-word burst ready for write-back to memory. Both paths take a burst index along the line. The within-line RAM address is derived from that index: four words per burst per line in range mode, two in azimuth mode.

Top module: `burst_line_router`

## Requirements
- R1: While `rst_n` is low, `wr_en`, `rd_en` and `gth_valid` are all zero, and `scat_ready` and `gth_ready` are one.
- R2: Range scatter (`scat_dir`=0, pair p, index i). The burst is accepted on a clock edge where `burst_valid` and `scat_ready` are both high. In the k-th cycle after that edge (k=0..3), RAM 2p writes word 2k and RAM 2p+1 writes word 2k+1, both at address 4i+k. The other two RAMs stay idle. Word w sits at `burst_data[64w+63:64w]`, and RAM b uses slice b of `wr_en`, `wr_addr` and `wr_data`.
- R3: Azimuth scatter (`scat_dir`=1, index i). In the k-th cycle after acceptance (k=0..1), every RAM r writes word 2r+k at address 2i+k. `scat_pair` has no effect in this mode.
- R4: A burst offered while `scat_ready` is low is ignored. It causes no RAM write at all.
- R5: After an acceptance, `scat_ready` (or `gth_ready`) is low for exactly 4 cycles in range mode and 2 cycles in azimuth mode. A new request can therefore be accepted every 5 or 3 cycles.
- R6: Gather reads are accepted on a clock edge where `gth_start` and `gth_ready` are both high. In the k-th cycle after that edge, `rd_en` and `rd_addr` follow the same RAM-and-address pattern as R2 (range) or R3 (azimuth). The RAM returns data on `rd_data` one cycle after each read.
- R7: The gathered burst appears on `gth_data` with `gth_valid` high for exactly one cycle, N+1 cycles after the acceptance edge, where N is 4 (range) or 2 (azimuth). In range mode, word 2k comes from RAM 2p and word 2k+1 from RAM 2p+1, using the data returned for beat k. In azimuth mode, word 2r+k comes from RAM r for beat k.
- R8: Scattering a burst and later gathering with the same direction, pair and index rebuilds the original 8 words in their original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_valid | input | 1 | A read burst is offered |
| burst_data | input | 8*WORD_W | Eight burst words, word w in slice w |
| scat_dir | input | 1 | Scatter traversal: 0 range, 1 azimuth |
| scat_pair | input | 1 | Scatter RAM pair in range mode: 0 RAM0/1, 1 RAM2/3 |
| scat_idx | input | ADDR_W | Burst index along the line for scatter |
| scat_ready | output | 1 | Scatter path can accept a burst |
| wr_en | output | 4 | Write enable per cache RAM |
| wr_addr | output | 4*ADDR_W | Write address per cache RAM |
| wr_data | output | 4*WORD_W | Write data per cache RAM |
| gth_start | input | 1 | Request to gather one burst |
| gth_dir | input | 1 | Gather traversal: 0 range, 1 azimuth |
| gth_pair | input | 1 | Gather RAM pair in range mode |
| gth_idx | input | ADDR_W | Burst index along the line for gather |
| gth_ready | output | 1 | Gather path can accept a request |
| rd_en | output | 4 | Read enable per cache RAM |
| rd_addr | output | 4*ADDR_W | Read address per cache RAM |
| rd_data | input | 4*WORD_W | Read data per cache RAM, one cycle after rd_en |
| gth_valid | output | 1 | Rebuilt burst present on gth_data |
| gth_data | output | 8*WORD_W | Rebuilt burst, word w in slice w |

## Verification
Counting from the edge that accepts a request as cycle 0, the write beats and the read beats fall in cycles 0 to N-1. The ready flag is back high in cycle N. The rebuilt burst is due in cycle N+1, because of one read-latency cycle and one capture register. When the bench drives a request, it stamps each expected write beat, read beat and rebuilt burst with the absolute cycle number at which it is due. A monitor running on the falling edge compares the ports only when its cycle counter matches that stamp. Any enable or valid that shows up with no item due is reported as an unexpected result. The ready flag is sampled on the first busy cycle and on the first free cycle after each acceptance.

// File: rtl/brc_pkg.sv
// Shared constants, traversal type and the word/RAM mapping helpers used
// by both the scatter and the gather path. Assumes an 8-word burst
// interleaved as 2 range lines x 4 azimuth lines, and four cache RAMs.
package brc_pkg;

    localparam int BURST_WORDS = 8;
    localparam int NUM_BANKS   = 4;
    localparam int BEAT_W      = 2;
    localparam int WSEL_W      = $clog2(BURST_WORDS);

    typedef enum logic {
        WALK_RANGE = 1'b0,
        WALK_AZIM  = 1'b1
    } walk_e;

    // True when a RAM takes part in a beat of the given traversal.
    function automatic logic bank_used(walk_e dir, logic pair, logic [1:0] bank);
        return (dir == WALK_AZIM) || (bank[1] == pair);
    endfunction

    // Burst word that belongs to a RAM in a given beat.
    // Range:   word = 2*beat + (bank mod 2); azimuth: word = 2*bank + beat.
    function automatic logic [WSEL_W-1:0] word_sel(walk_e dir, logic [1:0] bank,
                                                   logic [BEAT_W-1:0] beat);
        if (dir == WALK_AZIM) return {bank, beat[0]};
        return {beat, bank[0]};
    endfunction

    // Index of the final beat: 4 beats in range mode, 2 in azimuth mode.
    function automatic logic [BEAT_W-1:0] last_beat(walk_e dir);
        return (dir == WALK_AZIM) ? 2'd1 : 2'd3;
    endfunction

endpackage

// File: rtl/brc_beat_seq.sv
// Beat sequencer: after a start pulse it stays busy and counts beats
// until the final beat of the latched traversal. Assumes start is only
// raised while not busy and that dir is stable while busy.
module brc_beat_seq
    import brc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  walk_e             dir,
    output logic              busy,
    output logic [BEAT_W-1:0] beat,
    output logic              last
);

    assign last = busy && (beat == last_beat(dir));

    // Beat counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (start) begin
            busy <= 1'b1;
            beat <= '0;
        end else if (busy) begin
            beat <= beat + 2'd1;
            if (last) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/brc_scatter.sv
// Scatter path: latches one 8-word burst and writes its words into the
// four line-cache RAMs over 4 (range) or 2 (azimuth) beats, one word per
// active RAM per beat. Assumes the RAMs accept a write every cycle.
module brc_scatter
    import brc_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int ADDR_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [BURST_WORDS*WORD_W-1:0] in_words,
    input  walk_e                         in_dir,
    input  logic                          in_pair,
    input  logic [ADDR_W-1:0]             in_idx,
    output logic                          in_ready,
    output logic [NUM_BANKS-1:0]          wr_en,
    output logic [NUM_BANKS*ADDR_W-1:0]   wr_addr,
    output logic [NUM_BANKS*WORD_W-1:0]   wr_data
);

    logic              accept;
    logic              busy;
    logic              last;
    logic [BEAT_W-1:0] beat;
    walk_e             dir_q;
    logic              pair_q;
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] burst_q [BURST_WORDS];

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    // Traversal settings and line base address, captured on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= WALK_RANGE;
            pair_q <= 1'b0;
            base_q <= '0;
        end else if (accept) begin
            dir_q  <= in_dir;
            pair_q <= in_pair;
            base_q <= (in_dir == WALK_AZIM) ? (in_idx << 1) : (in_idx << 2);
        end
    end

    // Burst word store; data only, so no reset is needed.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < BURST_WORDS; i++) begin
                burst_q[i] <= in_words[i*WORD_W +: WORD_W];
            end
        end
    end

    brc_beat_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .dir   (dir_q),
        .busy  (busy),
        .beat  (beat),
        .last  (last)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign wr_en[b]                     = busy && bank_used(dir_q, pair_q, 2'(b));
        assign wr_addr[b*ADDR_W +: ADDR_W]  = base_q + ADDR_W'(beat);
        assign wr_data[b*WORD_W +: WORD_W]  = burst_q[word_sel(dir_q, 2'(b), beat)];
    end

endmodule

// File: rtl/brc_gather.sv
// Gather path: reads the four line-cache RAMs with the same beat pattern
// as the scatter path and rebuilds one 8-word burst. Assumes the RAMs
// return read data exactly one cycle after the read enable.
module brc_gather
    import brc_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int ADDR_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  walk_e                         st_dir,
    input  logic                          st_pair,
    input  logic [ADDR_W-1:0]             st_idx,
    output logic                          ready,
    output logic [NUM_BANKS-1:0]          rd_en,
    output logic [NUM_BANKS*ADDR_W-1:0]   rd_addr,
    input  logic [NUM_BANKS*WORD_W-1:0]   rd_data,
    output logic                          out_valid,
    output logic [BURST_WORDS*WORD_W-1:0] out_words
);

    logic              accept;
    logic              busy;
    logic              last;
    logic [BEAT_W-1:0] beat;
    walk_e             dir_q;
    logic              pair_q;
    logic [ADDR_W-1:0] base_q;
    logic              cap_valid_q;
    logic              cap_last_q;
    logic [BEAT_W-1:0] cap_beat_q;
    logic              out_valid_q;
    logic [WORD_W-1:0] words_q [BURST_WORDS];

    assign ready  = !busy;
    assign accept = start && ready;

    // Traversal settings and line base address, captured on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= WALK_RANGE;
            pair_q <= 1'b0;
            base_q <= '0;
        end else if (accept) begin
            dir_q  <= st_dir;
            pair_q <= st_pair;
            base_q <= (st_dir == WALK_AZIM) ? (st_idx << 1) : (st_idx << 2);
        end
    end

    brc_beat_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .dir   (dir_q),
        .busy  (busy),
        .beat  (beat),
        .last  (last)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign rd_en[b]                    = busy && bank_used(dir_q, pair_q, 2'(b));
        assign rd_addr[b*ADDR_W +: ADDR_W] = base_q + ADDR_W'(beat);
    end

    // Delay the beat tag by the RAM read latency and flag the burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid_q <= 1'b0;
            cap_last_q  <= 1'b0;
            cap_beat_q  <= '0;
            out_valid_q <= 1'b0;
        end else begin
            cap_valid_q <= busy;
            cap_last_q  <= last;
            cap_beat_q  <= beat;
            out_valid_q <= cap_valid_q && cap_last_q;
        end
    end

    // Place returned words at their burst positions (inverse mapping).
    always_ff @(posedge clk) begin
        if (cap_valid_q) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_used(dir_q, pair_q, 2'(b))) begin
                    words_q[word_sel(dir_q, 2'(b), cap_beat_q)] <= rd_data[b*WORD_W +: WORD_W];
                end
            end
        end
    end

    assign out_valid = out_valid_q;

    for (genvar w = 0; w < BURST_WORDS; w++) begin : g_word
        assign out_words[w*WORD_W +: WORD_W] = words_q[w];
    end

endmodule

// File: rtl/burst_line_router.sv
// Top: routes interleaved memory bursts into four line-cache RAMs and
// rebuilds bursts from them for write-back. The two paths are independent.
// Assumes RAM read latency of one cycle; RAMs sit outside this block.
module burst_line_router
    import brc_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int ADDR_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          burst_valid,
    input  logic [BURST_WORDS*WORD_W-1:0] burst_data,
    input  logic                          scat_dir,
    input  logic                          scat_pair,
    input  logic [ADDR_W-1:0]             scat_idx,
    output logic                          scat_ready,
    output logic [NUM_BANKS-1:0]          wr_en,
    output logic [NUM_BANKS*ADDR_W-1:0]   wr_addr,
    output logic [NUM_BANKS*WORD_W-1:0]   wr_data,
    input  logic                          gth_start,
    input  logic                          gth_dir,
    input  logic                          gth_pair,
    input  logic [ADDR_W-1:0]             gth_idx,
    output logic                          gth_ready,
    output logic [NUM_BANKS-1:0]          rd_en,
    output logic [NUM_BANKS*ADDR_W-1:0]   rd_addr,
    input  logic [NUM_BANKS*WORD_W-1:0]   rd_data,
    output logic                          gth_valid,
    output logic [BURST_WORDS*WORD_W-1:0] gth_data
);

    brc_scatter #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_scatter (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (burst_valid),
        .in_words (burst_data),
        .in_dir   (walk_e'(scat_dir)),
        .in_pair  (scat_pair),
        .in_idx   (scat_idx),
        .in_ready (scat_ready),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    brc_gather #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (gth_start),
        .st_dir    (walk_e'(gth_dir)),
        .st_pair   (gth_pair),
        .st_idx    (gth_idx),
        .ready     (gth_ready),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .out_valid (gth_valid),
        .out_words (gth_data)
    );

endmodule

// File: rtl/brc_router_checks.sv
// Property checker for burst_line_router, attached by bind below.
module brc_router_checks #(
    parameter int ADDR_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                burst_valid,
    input logic                scat_ready,
    input logic [3:0]          wr_en,
    input logic [4*ADDR_W-1:0] wr_addr,
    input logic                gth_start,
    input logic                gth_ready,
    input logic [3:0]          rd_en,
    input logic                gth_valid
);

    // R1: outputs quiet in the cycle after a reset edge.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (wr_en == 4'b0 && rd_en == 4'b0 && !gth_valid));

    // R2/R3: only one RAM pair, or all four RAMs, write together.
    p_write_groups_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 4'h0 || wr_en == 4'h3 || wr_en == 4'hC || wr_en == 4'hF));

    // R2: both RAMs of a range pair share one address.
    p_pair_same_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 4'h3) |-> (wr_addr[ADDR_W-1:0] == wr_addr[2*ADDR_W-1:ADDR_W]));

    // R3: second azimuth beat writes one address above the first.
    p_azim_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 4'hF && $past(wr_en) == 4'hF)
            |-> (wr_addr[ADDR_W-1:0] == $past(wr_addr[ADDR_W-1:0]) + ADDR_W'(1)));

    // R2: an accepted burst starts writing in the next cycle.
    p_accept_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && scat_ready) |=> (wr_en != 4'h0));

    // R4: never ready to accept while writes are in flight.
    p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != 4'h0) |-> !scat_ready);

    // R6: an accepted gather request starts reading in the next cycle.
    p_gather_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gth_start && gth_ready) |=> (rd_en != 4'h0));

    // R6: read enables follow the same grouping as writes.
    p_read_groups_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en == 4'h0 || rd_en == 4'h3 || rd_en == 4'hC || rd_en == 4'hF));

    // R7: the rebuilt burst is shown for a single cycle.
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gth_valid |=> !gth_valid);

endmodule

bind burst_line_router brc_router_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_valid (burst_valid),
    .scat_ready  (scat_ready),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .gth_start   (gth_start),
    .gth_ready   (gth_ready),
    .rd_en       (rd_en),
    .gth_valid   (gth_valid)
);

// File: tb/burst_line_router_tb_top.sv
// Scoreboard bench: driver tasks queue expected beats stamped with their
// due cycle; a falling-edge monitor pops and compares them.
module burst_line_router_tb_top;

    localparam int W = 64;
    localparam int A = 10;

    typedef struct packed {
        int             cyc;
        logic [3:0]     en;
        logic [4*A-1:0] addr;
        logic [4*W-1:0] data;
    } beat_t;

    typedef struct packed {
        int             cyc;
        logic [8*W-1:0] words;
    } burst_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           burst_valid = 1'b0;
    logic [8*W-1:0] burst_data = '0;
    logic           scat_dir = 1'b0, scat_pair = 1'b0;
    logic [A-1:0]   scat_idx = '0;
    logic           scat_ready;
    logic [3:0]     wr_en;
    logic [4*A-1:0] wr_addr;
    logic [4*W-1:0] wr_data;
    logic           gth_start = 1'b0, gth_dir = 1'b0, gth_pair = 1'b0;
    logic [A-1:0]   gth_idx = '0;
    logic           gth_ready;
    logic [3:0]     rd_en;
    logic [4*A-1:0] rd_addr;
    logic [4*W-1:0] rd_data;
    logic           gth_valid;
    logic [8*W-1:0] gth_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    beat_t  wq[$];
    string  wq_req[$];
    beat_t  rq[$];
    burst_t gq[$];
    string  gq_req[$];

    logic [W-1:0] ram_mem [4][1024];
    logic [W-1:0] ref_mem [4][1024];
    logic [W-1:0] rd_q [4];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    burst_line_router #(.WORD_W(W), .ADDR_W(A)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .burst_valid(burst_valid), .burst_data(burst_data),
        .scat_dir(scat_dir), .scat_pair(scat_pair), .scat_idx(scat_idx),
        .scat_ready(scat_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gth_start(gth_start), .gth_dir(gth_dir), .gth_pair(gth_pair), .gth_idx(gth_idx),
        .gth_ready(gth_ready), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .gth_valid(gth_valid), .gth_data(gth_data)
    );

    // Behavioural cache RAMs with one-cycle read latency.
    always @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            if (wr_en[b]) ram_mem[b][wr_addr[b*A +: A]] <= wr_data[b*W +: W];
            if (rd_en[b]) rd_q[b] <= ram_mem[b][rd_addr[b*A +: A]];
        end
    end
    assign rd_data = {rd_q[3], rd_q[2], rd_q[1], rd_q[0]};

    function automatic logic [W-1:0] mkword(input int tag, input int i);
        return {tag[31:0], i[31:0]};
    endfunction

    function automatic void chk(input bit ok, input string req, input string what,
                                input logic [8*W-1:0] act, input logic [8*W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Enable mask for a beat: range pair or all four RAMs (R2, R3).
    function automatic logic [3:0] mask_of(input logic dir, input logic pair);
        if (dir) return 4'hF;
        return pair ? 4'hC : 4'h3;
    endfunction

    // Burst word for RAM b in beat k (R2, R3).
    function automatic int src_of(input logic dir, input int b, input int k);
        if (dir) return 2*b + k;
        return 2*k + (b % 2);
    endfunction

    // Drive one scatter burst; optionally offer a second one while busy (R4).
    task automatic scat_send(input logic dir, input logic pair, input int idx,
                             input int tag, input bit poke, input string req);
        int n, nb, base;
        beat_t it;
        n = cyc;
        nb = dir ? 2 : 4;
        base = dir ? idx*2 : idx*4;
        burst_valid = 1'b1;
        scat_dir = dir;
        scat_pair = pair;
        scat_idx = A'(idx);
        for (int i = 0; i < 8; i++) burst_data[i*W +: W] = mkword(tag, i);
        for (int k = 0; k < nb; k++) begin
            it = '0;
            it.cyc = n + 1 + k;
            it.en = mask_of(dir, pair);
            for (int b = 0; b < 4; b++) begin
                if (it.en[b]) begin
                    it.addr[b*A +: A] = A'(base + k);
                    it.data[b*W +: W] = mkword(tag, src_of(dir, b, k));
                    ref_mem[b][base + k] = mkword(tag, src_of(dir, b, k));
                end
            end
            wq.push_back(it);
            wq_req.push_back(req);
        end
        @(negedge clk);
        chk(scat_ready == 1'b0, "R5", "scat_ready first busy cycle", 512'(scat_ready), 512'(0));
        if (poke) begin
            burst_valid = 1'b1;
            burst_data = {8*W{1'b1}};
            scat_dir = ~dir;
            scat_pair = ~pair;
        end else begin
            burst_valid = 1'b0;
        end
        @(negedge clk);
        burst_valid = 1'b0;
        repeat (nb - 1) @(negedge clk);
        chk(scat_ready == 1'b1, "R5", "scat_ready after last beat", 512'(scat_ready), 512'(1));
    endtask

    // Drive one gather request; tag != 0 expects the original burst (R8).
    task automatic gth_send(input logic dir, input logic pair, input int idx,
                            input int tag, input string req);
        int n, nb, base;
        beat_t it;
        burst_t g;
        n = cyc;
        nb = dir ? 2 : 4;
        base = dir ? idx*2 : idx*4;
        gth_start = 1'b1;
        gth_dir = dir;
        gth_pair = pair;
        gth_idx = A'(idx);
        g.cyc = n + nb + 2;
        g.words = '0;
        for (int k = 0; k < nb; k++) begin
            it = '0;
            it.cyc = n + 1 + k;
            it.en = mask_of(dir, pair);
            for (int b = 0; b < 4; b++) begin
                if (it.en[b]) begin
                    it.addr[b*A +: A] = A'(base + k);
                    g.words[src_of(dir, b, k)*W +: W] = ref_mem[b][base + k];
                end
            end
            rq.push_back(it);
        end
        if (tag != 0) begin
            for (int i = 0; i < 8; i++) g.words[i*W +: W] = mkword(tag, i);
        end
        gq.push_back(g);
        gq_req.push_back(req);
        @(negedge clk);
        chk(gth_ready == 1'b0, "R5", "gth_ready first busy cycle", 512'(gth_ready), 512'(0));
        gth_start = 1'b0;
        repeat (nb) @(negedge clk);
        chk(gth_ready == 1'b1, "R5", "gth_ready after last read", 512'(gth_ready), 512'(1));
    endtask

    // Monitor: compare due items, flag anything not expected.
    always @(negedge clk) begin
        beat_t  wi;
        burst_t gi;
        string  r;
        if (rst_n) begin
            if (wq.size() != 0 && wq[0].cyc == cyc) begin
                wi = wq.pop_front();
                r = wq_req.pop_front();
                chk(wr_en === wi.en, r, "wr_en", 512'(wr_en), 512'(wi.en));
                for (int b = 0; b < 4; b++) begin
                    if (wi.en[b]) begin
                        chk(wr_addr[b*A +: A] === wi.addr[b*A +: A], r, "wr_addr",
                            512'(wr_addr[b*A +: A]), 512'(wi.addr[b*A +: A]));
                        chk(wr_data[b*W +: W] === wi.data[b*W +: W], r, "wr_data",
                            512'(wr_data[b*W +: W]), 512'(wi.data[b*W +: W]));
                    end
                end
            end else if (wr_en != 4'h0) begin
                chk(1'b0, "R4", "unexpected write", 512'(wr_en), 512'(0));
            end
            if (rq.size() != 0 && rq[0].cyc == cyc) begin
                wi = rq.pop_front();
                chk(rd_en === wi.en, "R6", "rd_en", 512'(rd_en), 512'(wi.en));
                for (int b = 0; b < 4; b++) begin
                    if (wi.en[b]) begin
                        chk(rd_addr[b*A +: A] === wi.addr[b*A +: A], "R6", "rd_addr",
                            512'(rd_addr[b*A +: A]), 512'(wi.addr[b*A +: A]));
                    end
                end
            end else if (rd_en != 4'h0) begin
                chk(1'b0, "R6", "unexpected read", 512'(rd_en), 512'(0));
            end
            if (gq.size() != 0 && gq[0].cyc == cyc) begin
                gi = gq.pop_front();
                r = gq_req.pop_front();
                chk(gth_valid === 1'b1, "R7", "gth_valid due", 512'(gth_valid), 512'(1));
                chk(gth_data === gi.words, r, "gth_data", gth_data, gi.words);
            end else if (gth_valid) begin
                chk(1'b0, "R7", "gth_valid not due", 512'(gth_valid), 512'(0));
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 512'(cyc), 512'(0));
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_en == 4'h0 && rd_en == 4'h0 && !gth_valid, "R1", "outputs in reset",
            512'({wr_en, rd_en, gth_valid}), 512'(0));
        chk(scat_ready && gth_ready, "R1", "ready in reset",
            512'({scat_ready, gth_ready}), 512'(3));
        rst_n = 1'b1;
        @(negedge clk);

        scat_send(1'b0, 1'b0, 0, 32'hA1, 1'b1, "R2");   // range pair 0, busy offer ignored (R4)
        scat_send(1'b0, 1'b1, 0, 32'hB2, 1'b0, "R2");   // range pair 1, back to back
        scat_send(1'b1, 1'b1, 3, 32'hC3, 1'b0, "R3");   // azimuth, pair input ignored
        scat_send(1'b1, 1'b0, 4, 32'hD4, 1'b1, "R3");   // azimuth, busy offer ignored (R4)
        scat_send(1'b0, 1'b0, 3, 32'hE5, 1'b0, "R2");   // range pair 0, higher index
        @(negedge clk);

        gth_send(1'b1, 1'b0, 0, 0, "R7");                // azimuth across range-written lines
        gth_send(1'b0, 1'b1, 0, 32'hB2, "R8");
        gth_send(1'b1, 1'b0, 3, 32'hC3, "R8");
        gth_send(1'b0, 1'b0, 3, 32'hE5, "R8");
        gth_send(1'b1, 1'b1, 4, 32'hD4, "R8");
        gth_send(1'b0, 1'b0, 0, 0, "R7");
        repeat (6) @(negedge clk);

        chk(wq.size() == 0 && rq.size() == 0 && gq.size() == 0, "R7", "all items seen",
            512'(wq.size() + rq.size() + gq.size()), 512'(0));
        done = 1'b1;
        summary();
    end

endmodule